// File: doc/BRIEF.md
# I2C Master Command Queue Engine

This block is the byte-level part of an I2C master. Software writes command words into a transmit queue. Each word asks for one byte on the bus. It holds the byte to send, a flag that turns the word into a one-byte read, and a flag that closes the transfer with a STOP after that byte. Received bytes go into a receive queue, where software reads them back through the same register window.

Bit timing and the pads are outside the block. A bit-level sequencer performs each bus action that the block asks for: START, STOP, drive one bit, or sample one bit. It replies with a one-cycle done strobe, and for a sample it also returns the bit it read. The register window has the following controls:

- an enable request, and a separate enable status that follows the request only while the engine is idle;
- a 7-bit target address, which is locked while the engine is enabled;
- a status word;
- a stop-detected flag and an abort flag, each cleared when its register is read.

Top module: `i2cq_master`

## Requirements
- R1: After reset the enable status reads 0. The status word reads 0x06 (idle, transmit not full, transmit empty). The stop-detected and abort registers read 0, and no bus action is requested.
- R2: Writing bit 0 of the control register (index 0) changes the enable status (index 1, bit 0) only while the engine is idle. With the status at 0, queued commands cause no bus action.
- R3: Writes to the target register (index 2, bits 6:0) are dropped while the enable status is 1.
- R4: An idle, enabled engine with a non-empty transmit queue requests a START. It then drives the address byte {target, rw} MSB first, where rw is the read flag of the head command (1 = read), and then samples one acknowledge bit. Each action stays requested, with the same operation code, until its done strobe arrives.
- R5: A word written to the queue register (index 3) has its data in bits 7:0, its read flag in bit 8 and its stop flag in bit 9. A write word drives its 8 data bits MSB first and then samples one acknowledge bit.
- R6: A read word samples 8 bits MSB first and pushes the byte into the receive queue, ignoring its data field. It then drives an acknowledge bit: 0 normally, 1 when the word's stop flag is set.
- R7: A STOP is requested after the acknowledge of a word whose stop flag is set. Without that flag the engine holds the bus with no action requested and stays active until the next word arrives.
- R8: When the next word's direction differs from the current direction and no STOP came between them, the engine issues a repeated START and a new address byte.
- R9: A 1 sampled in any acknowledge slot after the address or a written byte sets the abort flag (status bit 4) and flushes the transmit queue. The engine then requests a STOP. Reading index 6 clears the abort flag.
- R10: The stop-detected flag (index 5, bit 0) sets when a STOP completes. A read of index 5 returns the flag and then clears it.
- R11: Status word (index 4): bit 0 engine active, bit 1 transmit not full, bit 2 transmit empty, bit 3 receive not empty, bit 4 abort.
- R12: Reading index 3 returns the oldest received byte in bits 7:0 and removes it from the receive queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed for the clear-on-read and pop side effects) |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| bit_req | output | 1 | A bus action is requested |
| bit_op | output | 2 | Action code: 0 START, 1 STOP, 2 drive bit, 3 sample bit |
| bit_out | output | 1 | Bit to drive for action code 2 |
| bit_done | input | 1 | One-cycle strobe: the requested action has finished |
| bit_in | input | 1 | Sampled bus bit, valid with bit_done for action code 3 |

## Verification
Each bus action is due one clock after the previous done strobe, because the engine registers its next state on that edge. The bench therefore records actions at their done strobes and does not count cycles. It compares the recorded sequence, entry by entry, with a list built arithmetically from the queued words and the scripted target replies. Register side effects (enable status, locked target, flags, queue pops) appear one edge after the access. The bench reads registers half a period before the edge, so it sees each value before the clear that the same read triggers, and any later read sees the updated state.

// File: rtl/i2cq_pkg.sv
`timescale 1ns/1ps
package i2cq_pkg;

  typedef struct packed {
    logic       stop;
    logic       rd;
    logic [7:0] data;
  } i2cq_cmd_t;

  localparam int CMD_W = $bits(i2cq_cmd_t);

  typedef enum logic [1:0] {
    BOP_START = 2'd0,
    BOP_STOP  = 2'd1,
    BOP_WR    = 2'd2,
    BOP_RD    = 2'd3
  } bop_e;

  localparam int REG_AW = 3;
  localparam logic [REG_AW-1:0] RA_CTRL   = 3'd0;
  localparam logic [REG_AW-1:0] RA_ENSTAT = 3'd1;
  localparam logic [REG_AW-1:0] RA_TARGET = 3'd2;
  localparam logic [REG_AW-1:0] RA_QUEUE  = 3'd3;
  localparam logic [REG_AW-1:0] RA_STATUS = 3'd4;
  localparam logic [REG_AW-1:0] RA_STOPDT = 3'd5;
  localparam logic [REG_AW-1:0] RA_ABORT  = 3'd6;

endpackage

// File: rtl/i2cq_fifo.sv
`timescale 1ns/1ps
module i2cq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  input  logic         flush,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp, wp_n, rp_n;
  logic [CW-1:0] cnt, cnt_n;
  logic          push_ok, pop_ok;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CMAX);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign dout    = mem[rp];

  always_comb begin
    wp_n  = wp;
    rp_n  = rp;
    cnt_n = cnt;
    if (flush) begin
      wp_n  = '0;
      rp_n  = '0;
      cnt_n = '0;
    end else begin
      if (push_ok) wp_n = (wp == LAST) ? '0 : wp + 1'b1;
      if (pop_ok)  rp_n = (rp == LAST) ? '0 : rp + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt_n = cnt + 1'b1;
        2'b01:   cnt_n = cnt - 1'b1;
        default: cnt_n = cnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      wp  <= wp_n;
      rp  <= rp_n;
      cnt <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  // R11
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt <= CMAX));

  // R9
  fifo_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);

endmodule

// File: rtl/i2cq_engine.sv
`timescale 1ns/1ps
module i2cq_engine
  import i2cq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en_req,
  input  logic [6:0] target,
  input  i2cq_cmd_t head,
  input  logic      tx_empty,
  input  logic      rx_full,
  output logic      tx_pop,
  output logic      tx_flush,
  output logic      rx_push,
  output logic [7:0] rx_byte,
  output logic      en_stat,
  output logic      active,
  output logic      stop_done,
  output logic      abort_set,
  output logic      bit_req,
  output bop_e      bit_op,
  output logic      bit_out,
  input  logic      bit_done,
  input  logic      bit_in
);
  localparam int BIT_W = $clog2(8);

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_ADDR, ST_AACK, ST_NEXT,
    ST_WBIT, ST_WACK, ST_RBIT, ST_RACK, ST_STOP
  } st_e;

  st_e              state, state_n;
  logic [7:0]       sh, sh_n, rxb, rxb_n;
  logic [BIT_W-1:0] cnt, cnt_n;
  logic             dir, dir_n, en_q, en_n;

  assign en_stat = en_q;
  assign active  = (state != ST_IDLE);
  assign rx_byte = rxb;
  assign bit_req = (state != ST_IDLE) && (state != ST_NEXT);
  assign bit_out = (state == ST_RACK) ? head.stop : sh[7];

  always_comb begin
    case (state)
      ST_START:                 bit_op = BOP_START;
      ST_STOP:                  bit_op = BOP_STOP;
      ST_ADDR, ST_WBIT, ST_RACK: bit_op = BOP_WR;
      default:                  bit_op = BOP_RD;
    endcase
  end

  always_comb begin
    state_n   = state;
    sh_n      = sh;
    cnt_n     = cnt;
    dir_n     = dir;
    rxb_n     = rxb;
    en_n      = en_q;
    tx_pop    = 1'b0;
    tx_flush  = 1'b0;
    rx_push   = 1'b0;
    stop_done = 1'b0;
    abort_set = 1'b0;
    case (state)
      ST_IDLE: begin
        en_n = en_req;
        if (en_q && !tx_empty) begin
          state_n = ST_START;
          dir_n   = head.rd;
        end
      end
      ST_START: if (bit_done) begin
        state_n = ST_ADDR;
        sh_n    = {target, dir};
        cnt_n   = '1;
      end
      ST_ADDR, ST_WBIT: if (bit_done) begin
        sh_n = {sh[6:0], 1'b0};
        if (cnt == '0) state_n = (state == ST_ADDR) ? ST_AACK : ST_WACK;
        else           cnt_n   = cnt - 1'b1;
      end
      ST_AACK: if (bit_done) begin
        if (bit_in) begin
          abort_set = 1'b1;
          tx_flush  = 1'b1;
          state_n   = ST_STOP;
        end else begin
          state_n = ST_NEXT;
        end
      end
      ST_NEXT: if (!tx_empty) begin
        if (head.rd != dir) begin
          state_n = ST_START;
          dir_n   = head.rd;
        end else if (head.rd) begin
          if (!rx_full) begin
            state_n = ST_RBIT;
            cnt_n   = '1;
          end
        end else begin
          state_n = ST_WBIT;
          sh_n    = head.data;
          cnt_n   = '1;
        end
      end
      ST_WACK: if (bit_done) begin
        if (bit_in) begin
          abort_set = 1'b1;
          tx_flush  = 1'b1;
          state_n   = ST_STOP;
        end else begin
          tx_pop  = 1'b1;
          state_n = head.stop ? ST_STOP : ST_NEXT;
        end
      end
      ST_RBIT: if (bit_done) begin
        rxb_n = {rxb[6:0], bit_in};
        if (cnt == '0) state_n = ST_RACK;
        else           cnt_n   = cnt - 1'b1;
      end
      ST_RACK: if (bit_done) begin
        rx_push = 1'b1;
        tx_pop  = 1'b1;
        state_n = head.stop ? ST_STOP : ST_NEXT;
      end
      ST_STOP: if (bit_done) begin
        stop_done = 1'b1;
        state_n   = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      sh    <= '0;
      rxb   <= '0;
      cnt   <= '0;
      dir   <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      state <= state_n;
      sh    <= sh_n;
      rxb   <= rxb_n;
      cnt   <= cnt_n;
      dir   <= dir_n;
      en_q  <= en_n;
    end
  end

  // R2
  en_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(en_q) |-> $past(state == ST_IDLE));

  // R4
  op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_req && !bit_done) |=> (bit_req && $stable(bit_op)));

  // R7
  stop_after_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STOP && !$stable(state)) |-> ($past(bit_done) && ($past(head.stop) || $past(bit_in))));

endmodule

// File: rtl/i2cq_master.sv
`timescale 1ns/1ps
module i2cq_master
  import i2cq_pkg::*;
#(
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        bit_req,
  output logic [1:0]  bit_op,
  output logic        bit_out,
  input  logic        bit_done,
  input  logic        bit_in
);
  logic        ctrl_q, target_we;
  logic [6:0]  target_q;
  logic        stopdet_q, abort_q;
  logic        tx_push, tx_pop, tx_flush, tx_empty, tx_full;
  logic        rx_push, rx_pop, rx_empty, rx_full;
  logic [CMD_W-1:0] tx_dout;
  logic [7:0]  rx_din, rx_dout;
  logic        en_stat, active, stop_done, abort_set;
  bop_e        op_e;
  logic        wr_ctrl, rd_stop, rd_abort;
  logic        unused_wdata;

  assign unused_wdata = ^reg_wdata[31:10];
  assign wr_ctrl   = reg_wr && (reg_addr == RA_CTRL);
  assign target_we = reg_wr && (reg_addr == RA_TARGET) && !en_stat;
  assign tx_push   = reg_wr && (reg_addr == RA_QUEUE);
  assign rx_pop    = reg_rd && (reg_addr == RA_QUEUE);
  assign rd_stop   = reg_rd && (reg_addr == RA_STOPDT);
  assign rd_abort  = reg_rd && (reg_addr == RA_ABORT);
  assign bit_op    = op_e;

  i2cq_fifo #(.W(CMD_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .din(reg_wdata[CMD_W-1:0]),
    .pop(tx_pop), .flush(tx_flush), .dout(tx_dout), .empty(tx_empty), .full(tx_full)
  );

  i2cq_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_din),
    .pop(rx_pop), .flush(1'b0), .dout(rx_dout), .empty(rx_empty), .full(rx_full)
  );

  i2cq_engine u_eng (
    .clk(clk), .rst_n(rst_n), .en_req(ctrl_q), .target(target_q),
    .head(i2cq_cmd_t'(tx_dout)), .tx_empty(tx_empty), .rx_full(rx_full),
    .tx_pop(tx_pop), .tx_flush(tx_flush), .rx_push(rx_push), .rx_byte(rx_din),
    .en_stat(en_stat), .active(active), .stop_done(stop_done), .abort_set(abort_set),
    .bit_req(bit_req), .bit_op(op_e), .bit_out(bit_out),
    .bit_done(bit_done), .bit_in(bit_in)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= 1'b0;
      target_q  <= '0;
      stopdet_q <= 1'b0;
      abort_q   <= 1'b0;
    end else begin
      if (wr_ctrl)   ctrl_q   <= reg_wdata[0];
      if (target_we) target_q <= reg_wdata[6:0];
      if (stop_done)    stopdet_q <= 1'b1;
      else if (rd_stop) stopdet_q <= 1'b0;
      if (abort_set)     abort_q <= 1'b1;
      else if (rd_abort) abort_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL:   reg_rdata[0]   = ctrl_q;
      RA_ENSTAT: reg_rdata[0]   = en_stat;
      RA_TARGET: reg_rdata[6:0] = target_q;
      RA_QUEUE:  reg_rdata[7:0] = rx_dout;
      RA_STATUS: reg_rdata[4:0] = {abort_q, !rx_empty, tx_empty, !tx_full, active};
      RA_STOPDT: reg_rdata[0]   = stopdet_q;
      RA_ABORT:  reg_rdata[0]   = abort_q;
      default:   reg_rdata      = '0;
    endcase
  end

  // R3
  target_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(target_q) |-> !$past(en_stat));

  // R10
  stopdet_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stopdet_q) |-> $past(bit_done && op_e == BOP_STOP));

  // R9
  abort_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abort_q) |-> tx_empty);

endmodule

// File: tb/tb_i2cq_master.sv
`timescale 1ns/1ps
module tb_i2cq_master;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        bit_req, bit_out, bit_done, bit_in;
  logic [1:0]  bit_op;

  int vectors = 0;
  int fails = 0;
  bit finished = 0;

  // bench-side model of the bit sequencer and the target replies
  logic [1:0] tr_op  [256];
  logic       tr_bit [256];
  int         n_tr;
  logic       rsp    [128];
  int         rd_idx;
  int         pcnt;
  logic       tr_clr;

  logic [1:0] ex_op  [256];
  logic       ex_bit [256];
  int         n_ex;
  int         n_rsp;

  always #2 clk = ~clk;

  i2cq_master dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bit_req(bit_req), .bit_op(bit_op), .bit_out(bit_out),
    .bit_done(bit_done), .bit_in(bit_in)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_tr <= 0; rd_idx <= 0; pcnt <= 0; bit_done <= 1'b0; bit_in <= 1'b0;
    end else if (tr_clr) begin
      n_tr <= 0; rd_idx <= 0; pcnt <= 0; bit_done <= 1'b0;
    end else begin
      bit_done <= 1'b0;
      if (bit_req && !bit_done) begin
        if (pcnt == 2) begin
          pcnt <= 0;
          bit_done <= 1'b1;
          if (n_tr < 256) begin
            tr_op[n_tr]  <= bit_op;
            tr_bit[n_tr] <= bit_out;
          end
          n_tr <= n_tr + 1;
          if (bit_op == 2'd3) begin
            bit_in <= (rd_idx < 128) ? rsp[rd_idx] : 1'b1;
            rd_idx <= rd_idx + 1;
          end
        end else begin
          pcnt <= pcnt + 1;
        end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(logic [2:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [2:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic new_case();
    n_ex = 0; n_rsp = 0;
    tr_clr = 1'b1;
    @(negedge clk);
    tr_clr = 1'b0;
  endtask

  task automatic ex_add(logic [1:0] op, logic b);
    ex_op[n_ex] = op; ex_bit[n_ex] = b; n_ex++;
  endtask
  task automatic ex_start(); ex_add(2'd0, 1'b0); endtask
  task automatic ex_stop();  ex_add(2'd1, 1'b0); endtask
  task automatic ex_wbyte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) ex_add(2'd2, b[i]);
  endtask
  task automatic ex_rbits(); for (int i = 0; i < 8; i++) ex_add(2'd3, 1'b0); endtask
  task automatic rsp_add(logic b); rsp[n_rsp] = b; n_rsp++; endtask
  task automatic rsp_byte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) rsp_add(b[i]);
  endtask

  task automatic cmp_trace(string tag);
    chk({tag, " action count"}, n_tr, n_ex);
    for (int i = 0; i < n_ex && i < n_tr; i++) begin
      chk({tag, " action code"}, int'(tr_op[i]), int'(ex_op[i]));
      if (ex_op[i] == 2'd2) chk({tag, " driven bit"}, int'(tr_bit[i]), int'(ex_bit[i]));
    end
  endtask

  task automatic wait_stop(string tag);
    logic [31:0] v;
    bit seen = 0;
    for (int k = 0; k < 3000 && !seen; k++) begin
      reg_read(3'd5, v);
      if (v[0]) seen = 1;
    end
    chk({tag, " R10 stop seen"}, int'(seen), 1);
    reg_read(3'd5, v);
    chk("R10 cleared by read", int'(v[0]), 0);
  endtask

  task automatic wait_en(logic want);
    logic [31:0] v;
    v = '0;
    for (int k = 0; k < 100; k++) begin
      reg_read(3'd1, v);
      if (v[0] == want) break;
    end
    chk("R2 enable status", int'(v[0]), int'(want));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [7:0]  d;
    logic [6:0]  tg;
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0; tr_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    reg_read(3'd1, v); chk("R1 enable status", int'(v), 0);
    reg_read(3'd4, v); chk("R1 status word", int'(v), 'h6);
    reg_read(3'd5, v); chk("R1 stop flag", int'(v), 0);
    reg_read(3'd6, v); chk("R1 abort flag", int'(v), 0);
    chk("R1 no bus action", int'(bit_req), 0);

    // R2: queued words wait while disabled; R4/R5/R7 write transfer
    new_case();
    reg_write(3'd2, 32'h2A);
    reg_write(3'd3, 32'h0A5);
    reg_write(3'd3, 32'h23C);
    repeat (30) @(negedge clk);
    chk("R2 idle while disabled", n_tr, 0);
    reg_read(3'd4, v); chk("R11 status two queued", int'(v), 'h2);
    reg_write(3'd0, 32'h1);
    wait_en(1'b1);
    reg_write(3'd2, 32'h55); // R3: dropped while enabled
    reg_read(3'd2, v); chk("R3 target locked", int'(v), 'h2A);
    ex_start(); ex_wbyte({7'h2A, 1'b0}); ex_add(2'd3, 0);
    ex_wbyte(8'hA5); ex_add(2'd3, 0);
    ex_wbyte(8'h3C); ex_add(2'd3, 0); ex_stop();
    for (int i = 0; i < 3; i++) rsp_add(1'b0);
    wait_stop("R7");
    cmp_trace("R4 R5 R7 write");

    // R5 sweep over data bytes, single write with stop
    for (int i = 0; i < 12; i++) begin
      d = 8'((i * 53 + 7) & 255);
      new_case();
      ex_start(); ex_wbyte({7'h2A, 1'b0}); ex_add(2'd3, 0);
      ex_wbyte(d); ex_add(2'd3, 0); ex_stop();
      rsp_add(0); rsp_add(0);
      reg_write(3'd3, {22'd0, 2'b10, d});
      wait_stop("R5");
      cmp_trace("R5 sweep");
    end

    // R6/R12: three reads, data fields ignored, last NACKed
    new_case();
    ex_start(); ex_wbyte({7'h2A, 1'b1}); ex_add(2'd3, 0);
    rsp_add(0);
    for (int i = 0; i < 3; i++) begin
      d = 8'((i * 91 + 30) & 255);
      rsp_byte(d);
      ex_rbits(); ex_add(2'd2, (i == 2));
    end
    ex_stop();
    reg_write(3'd3, 32'h1FF);
    reg_write(3'd3, 32'h1FF);
    reg_write(3'd3, 32'h3FF);
    wait_stop("R6");
    cmp_trace("R6 read acks");
    reg_read(3'd4, v); chk("R11 status rx pending", int'(v), 'hE);
    for (int i = 0; i < 3; i++) begin
      reg_read(3'd3, v);
      chk("R12 popped byte", int'(v), (i * 91 + 30) & 255);
    end
    reg_read(3'd4, v); chk("R12 rx drained", int'(v), 'h6);

    // R8: write then read without stop -> repeated START
    new_case();
    ex_start(); ex_wbyte({7'h2A, 1'b0}); ex_add(2'd3, 0);
    ex_wbyte(8'h96); ex_add(2'd3, 0);
    ex_start(); ex_wbyte({7'h2A, 1'b1}); ex_add(2'd3, 0);
    ex_rbits(); ex_add(2'd2, 1'b1); ex_stop();
    rsp_add(0); rsp_add(0); rsp_add(0); rsp_byte(8'h5E);
    reg_write(3'd3, 32'h096);
    reg_write(3'd3, 32'h300);
    wait_stop("R8");
    cmp_trace("R8 restart");
    reg_read(3'd3, v); chk("R8 read byte", int'(v), 'h5E);

    // R7: no stop flag holds the bus
    new_case();
    ex_start(); ex_wbyte({7'h2A, 1'b0}); ex_add(2'd3, 0);
    ex_wbyte(8'h81); ex_add(2'd3, 0);
    ex_wbyte(8'h42); ex_add(2'd3, 0); ex_stop();
    rsp_add(0); rsp_add(0); rsp_add(0);
    reg_write(3'd3, 32'h081);
    repeat (80) @(negedge clk);
    chk("R7 held actions", n_tr, 19);
    chk("R7 no request while held", int'(bit_req), 0);
    reg_read(3'd4, v); chk("R7 still active", int'(v), 'h7);
    reg_write(3'd3, 32'h242);
    wait_stop("R7");
    cmp_trace("R7 resumed");

    // R9: address NACK aborts and flushes
    new_case();
    ex_start(); ex_wbyte({7'h2A, 1'b0}); ex_add(2'd3, 0); ex_stop();
    rsp_add(1);
    reg_write(3'd3, 32'h011);
    reg_write(3'd3, 32'h022);
    reg_write(3'd3, 32'h233);
    wait_stop("R9");
    cmp_trace("R9 address nack");
    reg_read(3'd4, v); chk("R9 abort and flushed", int'(v), 'h16);
    reg_read(3'd6, v); chk("R9 abort read", int'(v), 1);
    reg_read(3'd4, v); chk("R9 abort cleared", int'(v), 'h6);

    // R9: data NACK on second byte
    new_case();
    ex_start(); ex_wbyte({7'h2A, 1'b0}); ex_add(2'd3, 0);
    ex_wbyte(8'hC3); ex_add(2'd3, 0); ex_stop();
    rsp_add(0); rsp_add(1);
    reg_write(3'd3, 32'h0C3);
    reg_write(3'd3, 32'h277);
    wait_stop("R9");
    cmp_trace("R9 data nack");
    reg_read(3'd4, v); chk("R9 flush after data nack", int'(v), 'h16);
    reg_read(3'd6, v);

    // R2/R3: disable, retarget, re-enable for several addresses
    for (int k = 0; k < 3; k++) begin
      tg = 7'((k * 45 + 19) & 127);
      reg_write(3'd0, 32'h0);
      wait_en(1'b0);
      reg_write(3'd2, {25'd0, tg});
      reg_read(3'd2, v); chk("R3 target accepted when disabled", int'(v), int'(tg));
      reg_write(3'd0, 32'h1);
      wait_en(1'b1);
      new_case();
      ex_start(); ex_wbyte({tg, 1'b1}); ex_add(2'd3, 0);
      ex_rbits(); ex_add(2'd2, 1'b1); ex_stop();
      rsp_add(0); rsp_byte(8'(k + 1));
      reg_write(3'd3, 32'h300);
      wait_stop("R4");
      cmp_trace("R4 retarget");
      reg_read(3'd3, v); chk("R12 retarget byte", int'(v), k + 1);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule